// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using a table of two-bit saturating counters. The fetch side presents a branch address and receives a taken or not-taken guess combinationally in the same cycle. The execute side later reports the resolved address and its real outcome. The block then moves the selected counter one step toward that outcome. In the same cycle it flags whether the stored guess was wrong.

The table is indexed by the address bits just above the two byte-offset bits. Instruction words are aligned, so those two bits are always zero and carry no information. There is no tag. Distinct branches whose index bits match therefore share one counter. A reset puts every counter into the weakly not-taken state. A small counter records how many resolved branches had been guessed correctly, and it either saturates or wraps, as a parameter selects.

Top module: `bht_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken), so every lookup predicts not taken and `hit_count` reads 0. A single taken update to an entry is enough to make it predict taken.
- R2: `lk_taken` equals bit 1 of the counter selected by `lk_addr`, and it is valid in the same cycle as the address. Counter codes: 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken.
- R3: An update with `upd_taken`=1 raises the selected counter by one step and holds it at 11. Four taken updates followed by one not-taken update still predict taken.
- R4: An update with `upd_taken`=0 lowers the selected counter by one step and holds it at 00. Four not-taken updates followed by one taken update still predict not taken.
- R5: The table index is `addr[IDX_W+1:2]`. Address bits 1:0 and all bits above the index are ignored, so addresses that match in the index bits select the same counter.
- R6: When a lookup and an update select the same counter in one cycle, `lk_taken` reflects the value before the update. The change is visible from the next cycle.
- R7: `upd_mispredict` is 1 in the update cycle exactly when `upd_valid`=1 and bit 1 of the selected counter differs from `upd_taken`. It is 0 whenever `upd_valid`=0.
- R8: `hit_count` rises by one in the cycle after each update with `upd_valid`=1 and `upd_mispredict`=0. With `STATS_SAT`=1 it holds at its maximum value.
- R9: While `upd_valid`=0, no counter changes, whatever values `upd_addr` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | ADDR_W | Branch address to predict |
| lk_taken | output | 1 | Prediction for `lk_addr` (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_mispredict | output | 1 | Stored guess differed from the outcome |
| hit_count | output | CNT_W | Number of correctly predicted updates |

## Verification
`lk_taken` and `upd_mispredict` are combinational. The bench drives inputs at the falling edge and samples them shortly after, before the next rising edge, so each update is checked against the counter state from before that edge. A counter change is first seen by a lookup in the cycle after its update. `hit_count` is sampled just after the rising edge that closes the update cycle. A bench-side reference table is advanced only after the combinational checks of each cycle. This keeps same-index collisions and aliased addresses on the same timing.

// File: rtl/bht_pkg.sv
package bht_pkg;

   typedef enum logic [1:0] {
      CTR_SNT = 2'b00,
      CTR_WNT = 2'b01,
      CTR_WT  = 2'b10,
      CTR_ST  = 2'b11
   } ctr_t;

   localparam ctr_t CTR_RESET = CTR_WNT;

   // one saturating step toward the resolved outcome
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      case (cur)
         CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
         CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
         CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
         default: nxt = taken ? CTR_ST  : CTR_WT;
      endcase
      return nxt;
   endfunction

   function automatic logic ctr_dir(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int ALIGN_BITS = 2;

   if (ADDR_W < IDX_W + ALIGN_BITS) begin : g_bad_width
      $error("bht_index: ADDR_W too small for index plus alignment bits");
   end

   assign idx = addr[ALIGN_BITS +: IDX_W];

   // alignment bits are always zero; upper bits are deliberately untagged
   logic unused_align;
   assign unused_align = ^addr[ALIGN_BITS-1:0];

   if (ADDR_W > IDX_W + ALIGN_BITS) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:IDX_W+ALIGN_BITS];
   end

endmodule

// File: rtl/bht_table.sv
module bht_table
   import bht_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_state,
   input  logic [IDX_W-1:0] wr_idx,
   output ctr_t             wr_state,
   input  logic             we,
   input  logic             wr_taken
);
   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("bht_table: DEPTH must equal 2**IDX_W");
   end

   ctr_t mem [DEPTH];

   // reads are combinational, so a same-cycle write is not yet visible
   assign rd_state = mem[rd_idx];
   assign wr_state = mem[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= CTR_RESET;
         end
      end else if (we) begin
         mem[wr_idx] <= ctr_step(wr_state, wr_taken);
      end
   end

   assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_taken && wr_state == CTR_ST) |=> (mem[$past(wr_idx)] == CTR_ST))
      else $error("counter left strongly taken on a taken update");

   assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wr_taken && wr_state == CTR_SNT) |=> (mem[$past(wr_idx)] == CTR_SNT))
      else $error("counter left strongly not taken on a not-taken update");

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (mem[$past(rd_idx)] == $past(rd_state)))
      else $error("counter changed without an update");

endmodule

// File: rtl/bht_stats.sv
module bht_stats #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("bht_stats: CNT_W must be at least 1");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        count <= '0;
         else if (bump && count != CNT_MAX) count <= count + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    count <= '0;
         else if (bump) count <= count + 1'b1;
      end
   end

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bump |=> $stable(count))
      else $error("hit count moved without a correct prediction");

   assert_bump_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !(SATURATE && count == CNT_MAX)) |=> (count == $past(count) + 1'b1))
      else $error("hit count did not advance by one");

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
   import bht_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DEPTH     = 1024,
   parameter int CNT_W     = 16,
   parameter bit STATS_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken,
   output logic              upd_mispredict,
   output logic [CNT_W-1:0]  hit_count
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bht_predictor: DEPTH must be a power of two, at least 2");
   end

   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;
   ctr_t             lk_state;
   ctr_t             up_state;

   bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_index (
      .addr (lk_addr),
      .idx  (lk_idx)
   );

   bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_up_index (
      .addr (upd_addr),
      .idx  (up_idx)
   );

   bht_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_state (lk_state),
      .wr_idx   (up_idx),
      .wr_state (up_state),
      .we       (upd_valid),
      .wr_taken (upd_taken)
   );

   assign lk_taken       = ctr_dir(lk_state);
   assign upd_mispredict = upd_valid && (ctr_dir(up_state) != upd_taken);

   bht_stats #(.CNT_W(CNT_W), .SATURATE(STATS_SAT)) u_stats (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (upd_valid && !upd_mispredict),
      .count (hit_count)
   );

   assert_mispredict_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_mispredict |-> upd_valid)
      else $error("mispredict flagged without an update");

   assert_same_index_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && lk_idx == up_idx) |-> (lk_taken == ctr_dir(up_state)))
      else $error("lookup disagrees with update port on a shared index");

endmodule

// File: tb/sim_bht_predictor.sv
`timescale 1ns/1ps
module sim_bht_predictor;
   localparam int ADDR_W = 16;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = 4;
   localparam int HMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] lk_addr = '0;
   logic              lk_taken;
   logic              upd_valid = 1'b0;
   logic [ADDR_W-1:0] upd_addr = '0;
   logic              upd_taken = 1'b0;
   logic              upd_mispredict;
   logic [CNT_W-1:0]  hit_count;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   logic [1:0] mdl [DEPTH];
   int         hits;

   always #4 clk = ~clk;

   bht_predictor #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .STATS_SAT(1'b1)) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .lk_addr        (lk_addr),
      .lk_taken       (lk_taken),
      .upd_valid      (upd_valid),
      .upd_addr       (upd_addr),
      .upd_taken      (upd_taken),
      .upd_mispredict (upd_mispredict),
      .hit_count      (hit_count)
   );

   function automatic int f_idx(input logic [ADDR_W-1:0] a);
      return int'(a[5:2]);
   endfunction

   function automatic logic [1:0] f_step(input logic [1:0] c, input logic t);
      if (t) return (c == 2'b11) ? 2'b11 : c + 2'b01;
      return (c == 2'b00) ? 2'b00 : c - 2'b01;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [ADDR_W-1:0] la, input logic uv,
                       input logic [ADDR_W-1:0] ua, input logic ut, input string tag);
      int li, ui;
      @(negedge clk);
      lk_addr = la; upd_valid = uv; upd_addr = ua; upd_taken = ut;
      #1;
      li = f_idx(la);
      ui = f_idx(ua);
      if (uv && li == ui) check("R6", "lk_taken on shared index", int'(lk_taken), int'(mdl[li][1]));
      else                check(tag, "lk_taken", int'(lk_taken), int'(mdl[li][1]));
      if (uv) check("R7", "upd_mispredict", int'(upd_mispredict), int'(mdl[ui][1] != ut));
      else    check("R7", "upd_mispredict idle", int'(upd_mispredict), 0);
      if (uv) begin
         if (mdl[ui][1] == ut && hits < HMAX) hits++;
         mdl[ui] = f_step(mdl[ui], ut);
      end
      @(posedge clk);
      #1;
      check("R8", "hit_count", int'(hit_count), hits);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung got %0d expected %0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] a, b;
      void'($urandom(32'd5150));
      for (int i = 0; i < DEPTH; i++) mdl[i] = 2'b01;
      hits = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state visible through every index
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         lk_addr = ADDR_W'(i << 2);
         #1;
         check("R1", "reset prediction", int'(lk_taken), 0);
      end
      check("R1", "reset hit_count", int'(hit_count), 0);
      // R1: one taken step from weakly not taken flips the prediction
      step(16'h000C, 1'b1, 16'h000C, 1'b1, "R1");
      step(16'h000C, 1'b0, 16'h0000, 1'b0, "R1");

      // R3: saturate high, then one not-taken step keeps taken
      for (int k = 0; k < 4; k++) step(16'h0000, 1'b1, 16'h0014, 1'b1, "R3");
      step(16'h0014, 1'b1, 16'h0014, 1'b0, "R3");
      step(16'h0014, 1'b1, 16'h0014, 1'b0, "R3");
      step(16'h0014, 1'b0, 16'h0000, 1'b0, "R3");

      // R4: saturate low, then one taken step keeps not taken
      for (int k = 0; k < 4; k++) step(16'h0000, 1'b1, 16'h0018, 1'b0, "R4");
      step(16'h0018, 1'b1, 16'h0018, 1'b1, "R4");
      step(16'h0018, 1'b0, 16'h0000, 1'b0, "R4");

      // R5: offset bits and upper bits ignored, aliases share a counter
      step(16'h0000, 1'b1, 16'h001F, 1'b1, "R5");
      step(16'h0000, 1'b1, 16'h005F, 1'b1, "R5");
      step(16'h001C, 1'b0, 16'h0000, 1'b0, "R5");
      step(16'hFF5C, 1'b0, 16'h0000, 1'b0, "R5");
      step(16'h0C1E, 1'b0, 16'h0000, 1'b0, "R5");

      // R6: same index looked up while updated
      step(16'h0020, 1'b1, 16'h0020, 1'b1, "R6");
      step(16'h0020, 1'b1, 16'h0020, 1'b1, "R6");
      step(16'h0020, 1'b0, 16'h0000, 1'b0, "R6");

      // R9: idle update port with active-looking data
      for (int k = 0; k < 4; k++) step(16'h0024, 1'b0, 16'h0024, 1'b1, "R9");

      // R2: random mix with aliasing and collisions
      for (int n = 0; n < 1500; n++) begin
         a = ADDR_W'($urandom_range(0, 255));
         b = ($urandom_range(0, 3) == 0) ? a : ADDR_W'($urandom_range(0, 1023));
         step(a, 1'($urandom_range(0, 1)), b, 1'($urandom_range(0, 2) != 0), "R2");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule